// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host write port and the program/erase engine of a small flash-like storage model. Each accepted host write is one bus cycle. Single-cycle commands pick what a read returns: stored words, identity codes, query data or the status byte. They also clear the sticky error flags. Two-cycle commands consist of a setup code followed by a second write. They launch a word program, a block erase, a block lock-bit set or a clear of every lock bit. Each launch is a one-cycle start pulse carrying the target address and data.

The decoder keeps one lock bit per block. It refuses to modify a locked block and reports the refusal in the status byte. Any launch, or any rejected second cycle, moves reads to status mode, and that mode stays until another mode command is written. Identity reads and lock commands are refused while the external engine reports busy.

The write port is a valid/ready stream. A write transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high at all times except one case: a two-cycle sequence is waiting for its second write and `eng_busy` is high. In that case the second write is held off until the engine is idle. The host must keep `wr_addr` and `wr_data` stable while `wr_valid` is high and `wr_ready` is low.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, read mode is array (`rd_mode`=0), every stored word reads FFFFh, every lock bit is clear, the error flags are clear and `wr_ready` is high.
- R2: A first-cycle code in `wr_data[7:0]` of FFh, 90h, 98h or 70h sets `rd_mode` to 0 (array), 1 (identity), 2 (query) or 3 (status) respectively. Any unrecognised first-cycle code leaves the mode unchanged. Query-mode reads return zero.
- R3: Code 50h pulses `stat_clr` for one cycle, clears status bits 5, 4 and 1, and leaves `rd_mode` unchanged.
- R4: Setup code 40h or 10h, followed by a write of address A and data D, pulses `op_prog` in the cycle after the second write, with `op_addr`=A and `op_data`=D. The stored word at A becomes its old value AND D, and `rd_mode` becomes 3.
- R5: Setup code 20h, followed by D0h at an address in block B, pulses `op_erase` and sets every word of block B to FFFFh. Other blocks are left unchanged.
- R6: Setup code 60h followed by 01h sets the lock bit of the block addressed by the second write, and pulses `op_lkset`. Setup 60h followed by D0h clears every lock bit and pulses `op_lkclr`.
- R7: In identity mode, offset 0 of block 0 reads the manufacturer code and offset 1 of block 0 reads the device code. Offset 2 of any block reads that block's lock bit in bit 0, with all other bits zero. All other identity addresses read zero. The address is split as block = upper bits, offset = low log2(WORDS_PER_BLK) bits.
- R8: A program or erase whose target block is locked leaves the stored words unchanged and issues no start pulse. It sets status bit 1, plus bit 4 for a program or bit 5 for an erase.
- R9: A second cycle other than D0h after 20h, or other than 01h/D0h after 60h, issues no start pulse, sets status bits 5 and 4, and sets `rd_mode` to 3.
- R10: While `eng_busy` is high, codes 90h and 60h are ignored: the mode is unchanged and no lock sequence opens.
- R11: With a second cycle pending and `eng_busy` high, `wr_ready` is low and no launch occurs. The held write is taken on the first edge after `eng_busy` falls.
- R12: The status byte reads in the low byte of `rd_data`, with the upper byte zero. Bit 7 is the inverse of `eng_busy`, bit 5 is the erase/sequence error, bit 4 is the program error and bit 1 is the lock refusal. Changes of `eng_busy` never alter `rd_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write cycle offered |
| wr_ready | output | 1 | Decoder takes the write on this edge |
| wr_addr | input | AW (6) | Write cycle address |
| wr_data | input | DW (16) | Write cycle data; command code in the low byte |
| rd_addr | input | AW (6) | Read address |
| rd_data | output | DW (16) | Read data for the current mode |
| eng_busy | input | 1 | External program/erase engine running |
| rd_mode | output | 2 | 0 array, 1 identity, 2 query, 3 status |
| op_prog | output | 1 | Program launch pulse |
| op_erase | output | 1 | Erase launch pulse |
| op_lkset | output | 1 | Lock-bit set launch pulse |
| op_lkclr | output | 1 | Clear-all-locks launch pulse |
| op_addr | output | AW (6) | Target address of the last launch |
| op_data | output | DW (16) | Data of the last launch |
| stat_clr | output | 1 | Status-clear request pulse |

## Verification
A wrong sequencer state shows up on the very next host write. Either a second-cycle value gets decoded as a first-cycle command, or a launch pulse and the status move into status mode appear when they should not. Both are visible on `rd_mode` and the `op_*` pulses one cycle after the edge that accepted the write. A corrupted lock bit appears as a refused or unrefused program in the status byte, and through identity offset 2, on the first read after the write. Errors in the storage model only show up when the word is read back in array mode, so every program and erase is followed by array reads of the touched word and of a word in a neighbouring block.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_QUERY  = 2'd2,
    RM_STATUS = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PROG  = 2'd1,
    SQ_ERASE = 2'd2,
    SQ_LOCK  = 2'd3
  } seq_e;

  typedef struct packed {
    logic err_erase;
    logic err_prog;
    logic err_lock;
  } flags_t;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROG_A  = 8'h40;
  localparam logic [7:0] CMD_PROG_B  = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_LOCK    = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_LKSET   = 8'h01;
endpackage

// File: rtl/fcmd_lock_bank.sv
module fcmd_lock_bank #(
  parameter int BLKS = 4,
  localparam int BW = (BLKS > 1) ? $clog2(BLKS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [BW-1:0]   set_blk,
  input  logic            clr_all,
  output logic [BLKS-1:0] lock_q
);
  for (genvar b = 0; b < BLKS; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                               lock_q[b] <= 1'b0;
      else if (clr_all)                         lock_q[b] <= 1'b0;
      else if (set_en && set_blk == BW'(b))     lock_q[b] <= 1'b1;
    end
  end

  // R6: a clear-all leaves no block locked
  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (lock_q == '0));
  // R6: a set request locks the addressed block
  p_set_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_all) |=> lock_q[$past(set_blk)]);
endmodule

// File: rtl/fcmd_store.sv
module fcmd_store #(
  parameter int DW   = 16,
  parameter int AW   = 6,
  parameter int OFFW = 4,
  localparam int BW    = AW - OFFW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic          erase_en,
  input  logic [BW-1:0] erase_blk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam int GBLK = g >> OFFW;
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '1;
      else if (erase_en && erase_blk == BW'(GBLK))
        word_q <= '1;
      else if (prog_en && prog_addr == AW'(g))
        word_q <= word_q & prog_data;   // programming only clears bits
    end
    assign words[g] = word_q;
  end

  assign rd_word = words[rd_addr];

  // R5: after an erase the erased block's words read all ones
  p_erase_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_en && rd_addr[AW-1:OFFW] == erase_blk) |=> (rd_word == '1) || !$stable(rd_addr));
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 6,
  parameter int OFFW = 4,
  parameter int BLKS = 4,
  localparam int BW  = AW - OFFW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            eng_busy,
  input  logic [BLKS-1:0] lock_vec,
  output rmode_e          mode_q,
  output flags_t          flags_q,
  output logic            do_prog,
  output logic            do_erase,
  output logic            do_lkset,
  output logic            do_lkclr,
  output logic            op_prog,
  output logic            op_erase,
  output logic            op_lkset,
  output logic            op_lkclr,
  output logic [AW-1:0]   op_addr,
  output logic [DW-1:0]   op_data,
  output logic            stat_clr
);
  seq_e    state_q, state_d;
  rmode_e  mode_d;
  flags_t  flags_d;
  logic    clr_d;
  logic    fire;
  logic [7:0]    cmd;
  logic [BW-1:0] blk;
  logic          tgt_locked;

  assign cmd        = wr_data[7:0];
  assign blk        = wr_addr[AW-1:OFFW];
  assign tgt_locked = lock_vec[blk];
  assign wr_ready   = (state_q == SQ_IDLE) || !eng_busy;
  assign fire       = wr_valid && wr_ready;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    flags_d  = flags_q;
    clr_d    = 1'b0;
    do_prog  = 1'b0;
    do_erase = 1'b0;
    do_lkset = 1'b0;
    do_lkclr = 1'b0;
    if (fire) begin
      unique case (state_q)
        SQ_IDLE: begin
          case (cmd)
            CMD_ARRAY:  mode_d = RM_ARRAY;
            CMD_IDENT:  if (!eng_busy) mode_d = RM_IDENT;
            CMD_QUERY:  mode_d = RM_QUERY;
            CMD_STATUS: mode_d = RM_STATUS;
            CMD_CLEAR: begin
              clr_d   = 1'b1;
              flags_d = '0;
            end
            CMD_PROG_A, CMD_PROG_B: state_d = SQ_PROG;
            CMD_ERASE:  state_d = SQ_ERASE;
            CMD_LOCK:   if (!eng_busy) state_d = SQ_LOCK;
            default: ;
          endcase
        end
        SQ_PROG: begin
          state_d = SQ_IDLE;
          mode_d  = RM_STATUS;
          if (tgt_locked) begin
            flags_d.err_prog = 1'b1;
            flags_d.err_lock = 1'b1;
          end else begin
            do_prog = 1'b1;
          end
        end
        SQ_ERASE: begin
          state_d = SQ_IDLE;
          mode_d  = RM_STATUS;
          if (cmd != CMD_CONFIRM) begin
            flags_d.err_erase = 1'b1;
            flags_d.err_prog  = 1'b1;
          end else if (tgt_locked) begin
            flags_d.err_erase = 1'b1;
            flags_d.err_lock  = 1'b1;
          end else begin
            do_erase = 1'b1;
          end
        end
        SQ_LOCK: begin
          state_d = SQ_IDLE;
          mode_d  = RM_STATUS;
          if (cmd == CMD_LKSET)        do_lkset = 1'b1;
          else if (cmd == CMD_CONFIRM) do_lkclr = 1'b1;
          else begin
            flags_d.err_erase = 1'b1;
            flags_d.err_prog  = 1'b1;
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      mode_q   <= RM_ARRAY;
      flags_q  <= '0;
      op_prog  <= 1'b0;
      op_erase <= 1'b0;
      op_lkset <= 1'b0;
      op_lkclr <= 1'b0;
      stat_clr <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      flags_q  <= flags_d;
      op_prog  <= do_prog;
      op_erase <= do_erase;
      op_lkset <= do_lkset;
      op_lkclr <= do_lkclr;
      stat_clr <= clr_d;
      if (do_prog || do_erase || do_lkset || do_lkclr) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
    end
  end

  // R4: at most one launch pulse per cycle
  p_one_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_prog, op_erase, op_lkset, op_lkclr}));
  // R4: a launch is always seen with reads in status mode
  p_launch_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_prog || op_erase || op_lkset || op_lkclr) |-> (mode_q == RM_STATUS));
  // R11: no launch follows a cycle where the engine was busy
  p_no_busy_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (do_prog || do_erase || do_lkset || do_lkclr) |=> $past(!eng_busy));
  // R10: identity request during busy keeps the mode
  p_ident_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && state_q == SQ_IDLE && cmd == CMD_IDENT && eng_busy) |=> $stable(mode_q));
  // R12: without an accepted write the mode holds
  p_mode_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(mode_q));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int          DW            = 16,
  parameter int          BLKS          = 4,
  parameter int          WORDS_PER_BLK = 16,
  parameter logic [15:0] MFR_ID        = 16'h0047,
  parameter logic [15:0] DEV_ID        = 16'h0031,
  localparam int OFFW = $clog2(WORDS_PER_BLK),
  localparam int BW   = $clog2(BLKS),
  localparam int AW   = OFFW + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          eng_busy,
  output logic [1:0]    rd_mode,
  output logic          op_prog,
  output logic          op_erase,
  output logic          op_lkset,
  output logic          op_lkclr,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          stat_clr
);
  rmode_e          mode_q;
  flags_t          flags_q;
  logic            do_prog, do_erase, do_lkset, do_lkclr;
  logic [BLKS-1:0] lock_q;
  logic [DW-1:0]   arr_word;
  logic [7:0]      stat_byte;
  logic [OFFW-1:0] rd_off;
  logic [BW-1:0]   rd_blk;

  fcmd_seq #(.DW(DW), .AW(AW), .OFFW(OFFW), .BLKS(BLKS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .lock_vec(lock_q),
    .mode_q(mode_q), .flags_q(flags_q),
    .do_prog(do_prog), .do_erase(do_erase),
    .do_lkset(do_lkset), .do_lkclr(do_lkclr),
    .op_prog(op_prog), .op_erase(op_erase),
    .op_lkset(op_lkset), .op_lkclr(op_lkclr),
    .op_addr(op_addr), .op_data(op_data),
    .stat_clr(stat_clr)
  );

  fcmd_lock_bank #(.BLKS(BLKS)) u_locks (
    .clk(clk), .rst_n(rst_n),
    .set_en(do_lkset), .set_blk(wr_addr[AW-1:OFFW]),
    .clr_all(do_lkclr), .lock_q(lock_q)
  );

  fcmd_store #(.DW(DW), .AW(AW), .OFFW(OFFW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .prog_en(do_prog), .prog_addr(wr_addr), .prog_data(wr_data),
    .erase_en(do_erase), .erase_blk(wr_addr[AW-1:OFFW]),
    .rd_addr(rd_addr), .rd_word(arr_word)
  );

  assign rd_off    = rd_addr[OFFW-1:0];
  assign rd_blk    = rd_addr[AW-1:OFFW];
  assign stat_byte = {!eng_busy, 1'b0, flags_q.err_erase, flags_q.err_prog,
                      2'b00, flags_q.err_lock, 1'b0};
  assign rd_mode   = mode_q;

  always_comb begin
    rd_data = '0;
    unique case (mode_q)
      RM_ARRAY:  rd_data = arr_word;
      RM_IDENT: begin
        if (rd_blk == '0 && rd_off == OFFW'(0))      rd_data = DW'(MFR_ID);
        else if (rd_blk == '0 && rd_off == OFFW'(1)) rd_data = DW'(DEV_ID);
        else if (rd_off == OFFW'(2))                 rd_data = {{(DW-1){1'b0}}, lock_q[rd_blk]};
      end
      RM_QUERY:  rd_data = '0;
      RM_STATUS: rd_data = {{(DW-8){1'b0}}, stat_byte};
      default:   rd_data = '0;
    endcase
  end

  // R12: upper byte is zero whenever status is read
  p_status_upper_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RM_STATUS) |-> (rd_data[DW-1:8] == '0));
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        eng_busy = 1'b0;
  logic [1:0]  rd_mode;
  logic        op_prog, op_erase, op_lkset, op_lkclr, stat_clr;
  logic [5:0]  op_addr;
  logic [15:0] op_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_cmd_ctrl u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .eng_busy(eng_busy), .rd_mode(rd_mode), .op_prog(op_prog), .op_erase(op_erase),
    .op_lkset(op_lkset), .op_lkclr(op_lkclr), .op_addr(op_addr), .op_data(op_data),
    .stat_clr(stat_clr)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 mode after reset", rd_mode, 0);
    chk("R1 ready after reset", wr_ready, 1);
    rd(6'h00, v); chk("R1 word 0 erased", v, 16'hFFFF);
    rd(6'h37, v); chk("R1 word 37 erased", v, 16'hFFFF);
    bus_wr(6'h00, 16'h0070);
    rd(6'h00, v); chk("R1 status clean", v, 16'h0080);
    bus_wr(6'h00, 16'h0090);
    rd(6'h22, v); chk("R1 lock clear blk2", v, 0);
  endtask

  task automatic t_modes;
    logic [15:0] v;
    bus_wr(6'h00, 16'h0090); chk("R2 ident mode", rd_mode, 1);
    rd(6'h00, v); chk("R7 manufacturer", v, 16'h0047);
    rd(6'h01, v); chk("R7 device", v, 16'h0031);
    rd(6'h10, v); chk("R7 blk1 off0 zero", v, 0);
    rd(6'h05, v); chk("R7 other offset zero", v, 0);
    bus_wr(6'h00, 16'h0098); chk("R2 query mode", rd_mode, 2);
    rd(6'h03, v); chk("R2 query zero", v, 0);
    bus_wr(6'h00, 16'h0033); chk("R2 unknown ignored", rd_mode, 2);
    bus_wr(6'h00, 16'h0070); chk("R2 status mode", rd_mode, 3);
    bus_wr(6'h00, 16'h00FF); chk("R2 array mode", rd_mode, 0);
  endtask

  task automatic t_program;
    logic [15:0] v;
    bus_wr(6'h00, 16'h0040);
    chk("R4 no pulse on setup", op_prog, 0);
    bus_wr(6'h05, 16'h1234);
    chk("R4 prog pulse", op_prog, 1);
    chk("R4 prog addr", op_addr, 6'h05);
    chk("R4 prog data", op_data, 16'h1234);
    chk("R4 mode status", rd_mode, 3);
    rd(6'h05, v); chk("R12 status after prog", v, 16'h0080);
    bus_wr(6'h00, 16'h00FF);
    rd(6'h05, v); chk("R4 word programmed", v, 16'h1234);
    bus_wr(6'h00, 16'h0010);
    bus_wr(6'h05, 16'h0F0F);
    chk("R4 alt setup pulse", op_prog, 1);
    bus_wr(6'h00, 16'h00FF);
    rd(6'h05, v); chk("R4 AND of old and new", v, 16'h0204);
  endtask

  task automatic t_erase;
    logic [15:0] v;
    bus_wr(6'h00, 16'h0040); bus_wr(6'h15, 16'h00AA);
    bus_wr(6'h00, 16'h00FF);
    rd(6'h15, v); chk("R4 blk1 word set", v, 16'h00AA);
    bus_wr(6'h13, 16'h0020); bus_wr(6'h13, 16'h00D0);
    chk("R5 erase pulse", op_erase, 1);
    chk("R5 erase addr", op_addr, 6'h13);
    bus_wr(6'h00, 16'h00FF);
    rd(6'h15, v); chk("R5 blk1 erased", v, 16'hFFFF);
    rd(6'h05, v); chk("R5 blk0 untouched", v, 16'h0204);
  endtask

  task automatic t_lock;
    logic [15:0] v;
    bus_wr(6'h20, 16'h0060); bus_wr(6'h20, 16'h0001);
    chk("R6 lock set pulse", op_lkset, 1);
    bus_wr(6'h00, 16'h0090);
    rd(6'h22, v); chk("R6 blk2 locked", v, 1);
    rd(6'h02, v); chk("R7 blk0 lock bit", v, 0);
    rd(6'h32, v); chk("R7 blk3 lock bit", v, 0);
    bus_wr(6'h00, 16'h0040); bus_wr(6'h21, 16'h0000);
    chk("R8 no prog pulse locked", op_prog, 0);
    rd(6'h00, v); chk("R8 prog lock status", v, 16'h0092);
    bus_wr(6'h00, 16'h00FF);
    rd(6'h21, v); chk("R8 locked word kept", v, 16'hFFFF);
    bus_wr(6'h00, 16'h0050);
    chk("R3 clear pulse", stat_clr, 1);
    chk("R3 mode kept", rd_mode, 0);
    bus_wr(6'h00, 16'h0070);
    rd(6'h00, v); chk("R3 flags cleared", v, 16'h0080);
    bus_wr(6'h24, 16'h0020); bus_wr(6'h24, 16'h00D0);
    chk("R8 no erase pulse locked", op_erase, 0);
    rd(6'h00, v); chk("R8 erase lock status", v, 16'h00A2);
    bus_wr(6'h00, 16'h0050);
    bus_wr(6'h00, 16'h0060); bus_wr(6'h00, 16'h00D0);
    chk("R6 clear-all pulse", op_lkclr, 1);
    bus_wr(6'h00, 16'h0090);
    rd(6'h22, v); chk("R6 blk2 unlocked", v, 0);
    bus_wr(6'h00, 16'h0040); bus_wr(6'h21, 16'h1111);
    chk("R6 prog after unlock", op_prog, 1);
  endtask

  task automatic t_badconf;
    logic [15:0] v;
    bus_wr(6'h00, 16'h00FF);
    bus_wr(6'h00, 16'h0020); bus_wr(6'h00, 16'h0055);
    chk("R9 no erase pulse", op_erase, 0);
    chk("R9 mode status", rd_mode, 3);
    rd(6'h00, v); chk("R9 erase seq error", v, 16'h00B0);
    bus_wr(6'h00, 16'h0050);
    bus_wr(6'h00, 16'h0060); bus_wr(6'h00, 16'h0077);
    chk("R9 no lock pulses", {op_lkset, op_lkclr}, 0);
    rd(6'h00, v); chk("R9 lock seq error", v, 16'h00B0);
    bus_wr(6'h00, 16'h0050);
  endtask

  task automatic t_busy;
    logic [15:0] v;
    bus_wr(6'h00, 16'h0070);
    eng_busy = 1'b1;
    rd(6'h00, v); chk("R12 busy status", v, 16'h0000);
    @(negedge clk); chk("R12 mode kept on busy", rd_mode, 3);
    bus_wr(6'h00, 16'h0090); chk("R10 ident ignored busy", rd_mode, 3);
    bus_wr(6'h30, 16'h0060); bus_wr(6'h30, 16'h0001);
    chk("R10 lock ignored busy", op_lkset, 0);
    bus_wr(6'h00, 16'h0040);
    @(negedge clk);
    wr_addr = 6'h06; wr_data = 16'h00F0; wr_valid = 1'b1;
    #1 chk("R11 ready low pending", wr_ready, 0);
    @(negedge clk);
    chk("R11 no launch busy", op_prog, 0);
    chk("R11 still stalled", wr_ready, 0);
    eng_busy = 1'b0;
    #1 chk("R11 ready after idle", wr_ready, 1);
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R11 held write launched", op_prog, 1);
    chk("R11 held addr", op_addr, 6'h06);
    chk("R12 mode kept on idle", rd_mode, 3);
    bus_wr(6'h00, 16'h0090);
    rd(6'h32, v); chk("R10 blk3 not locked", v, 0);
    bus_wr(6'h00, 16'h00FF);
    rd(6'h06, v); chk("R11 held word stored", v, 16'h00F0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_modes;
    t_program;
    t_erase;
    t_lock;
    t_badconf;
    t_busy;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule